// File: doc/BRIEF.md
# Burst Read Master with Short-Packet Commit

This block is a synchronous master that pulls words from an external slave over a parallel data bus into a fixed-size receive buffer. It waits in idle until the buffer is reported free. It then raises a read strobe and captures one word per clock. Each word goes to the buffer write port with a word address that starts at zero for every burst.

The burst length is set by a down-counter. At burst start the counter is preloaded with the buffer depth in words minus one, and a terminal count of zero ends the burst. When the counter reaches zero on a captured word, the buffer is full. The machine returns straight to idle and issues a full-commit pulse. The buffer-ready level is never used to stop a burst, because it reports full one clock too late.

If the slave raises its end-of-data flag before the last word, that cycle carries no data. The machine then spends one cycle in a short state. There it pulses a short-commit request and presents the number of valid bytes, so the partly filled buffer can be closed out. If the slave always delivers a whole buffer, the end-of-data input can be tied low. The bus width (1 or 4 bytes) and the buffer size are parameters.

Top module: `burst_read_master`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle, with rd_strobe, wr_en, commit_full and short_commit low and short_bytes at zero.
- R2: A burst starts only when buf_free is high while the machine is idle. rd_strobe rises on the cycle after buf_free is sampled high, and it stays low while buf_free is low.
- R3: rd_strobe is high only during the data phase. Each data-phase cycle without end-of-data writes rd_data to wr_data with wr_en high. The wr_addr values run 0, 1, 2, and so on within a burst.
- R4: With no end-of-data, a burst writes exactly BUF_BYTES/BUS_BYTES words. commit_full is high for exactly one cycle, on the cycle after the last word, and rd_strobe is low on that cycle. short_commit stays low.
- R5: If eod is high in a data-phase cycle before the last word, wr_en is low in that cycle. On the next cycle short_commit is high and rd_strobe is low, with short_bytes equal to the words already written times BUS_BYTES. commit_full stays low.
- R6: If eod is high on the cycle of the last word, that word is written and the burst ends as a full burst (R4), with no short commit.
- R7: eod has no effect while the machine is idle.
- R8: short_commit lasts exactly one cycle, and the machine is then idle and can start a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_free | input | 1 | Receive buffer is free; starts a burst from idle |
| eod | input | 1 | Slave has no more data (end of data) |
| rd_data | input | 8*BUS_BYTES | Word from the slave |
| rd_strobe | output | 1 | Read strobe to the slave, high in the data phase |
| wr_en | output | 1 | Buffer write enable |
| wr_addr | output | $clog2(BUF_BYTES/BUS_BYTES) | Word address in the buffer |
| wr_data | output | 8*BUS_BYTES | Word written to the buffer |
| commit_full | output | 1 | One-cycle pulse: the full buffer is committed |
| short_commit | output | 1 | One-cycle pulse: the partial buffer is committed |
| short_bytes | output | $clog2(BUF_BYTES+1) | Valid byte count of the partial buffer |

## Verification
If the word counter is wrong, a full burst writes too few or too many words. That shows up at once as a missing or misplaced commit_full pulse, and as wr_addr leaving the 0-to-last sequence. A wrong state choice on end-of-data shows on the very next cycle. The symptoms are a short_commit where a full commit was due, or the reverse, or a wrong short_bytes. The bench therefore checks every data cycle, plus the one or two cycles after each burst, for bursts cut short at random points, at the first word, at the word before last and at the last word.

// File: rtl/burst_read_master.sv
module burst_read_master #(
  parameter int BUS_BYTES = 4,
  parameter int BUF_BYTES = 512
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             buf_free,
  input  logic                             eod,
  input  logic [8*BUS_BYTES-1:0]           rd_data,
  output logic                             rd_strobe,
  output logic                             wr_en,
  output logic [$clog2(BUF_BYTES/BUS_BYTES)-1:0] wr_addr,
  output logic [8*BUS_BYTES-1:0]           wr_data,
  output logic                             commit_full,
  output logic                             short_commit,
  output logic [$clog2(BUF_BYTES+1)-1:0]   short_bytes
);
  localparam int WORDS = BUF_BYTES / BUS_BYTES;
  localparam int CW    = $clog2(WORDS);
  localparam int BW    = $clog2(BUF_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_SHORT} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          hit;

  assign hit          = (cnt == '0);
  assign rd_strobe    = (state == S_DATA);
  assign wr_en        = rd_strobe && (hit || !eod);
  assign wr_addr      = LAST - cnt;
  assign wr_data      = rd_data;
  assign short_commit = (state == S_SHORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      cnt         <= '0;
      commit_full <= 1'b0;
      short_bytes <= '0;
    end else begin
      commit_full <= 1'b0;
      case (state)
        S_IDLE: if (buf_free) begin
          state <= S_DATA;
          cnt   <= LAST;
        end
        S_DATA: begin
          if (hit) begin
            state       <= S_IDLE;
            commit_full <= 1'b1;
          end else if (eod) begin
            state       <= S_SHORT;
            short_bytes <= BW'(wr_addr) * BW'(BUS_BYTES);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_start_needs_free: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_strobe) |-> $past(buf_free));

  a_r3_addr_steps: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && $past(rd_strobe) && $past(wr_en) && wr_en) |-> wr_addr == $past(wr_addr) + 1'b1);

  a_r4_commit_after_last: assert property (@(posedge clk) disable iff (rst)
    commit_full |-> ($past(wr_en) && $past(wr_addr) == LAST && !rd_strobe));

  a_r6_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(commit_full && short_commit));

  a_r8_short_one_cycle: assert property (@(posedge clk) disable iff (rst)
    short_commit |=> (!short_commit && !rd_strobe));
endmodule

// File: tb/tb_burst_read_master.sv
`timescale 1ns/1ps
module tb_burst_read_master;
  localparam int BB    = 4;
  localparam int BUFB  = 64;
  localparam int WORDS = BUFB / BB;
  localparam int CW    = $clog2(WORDS);
  localparam int BW    = $clog2(BUFB + 1);

  logic clk = 0, rst = 1, buf_free = 0, eod = 0;
  logic [8*BB-1:0] rd_data = '0;
  logic rd_strobe, wr_en, commit_full, short_commit;
  logic [CW-1:0] wr_addr;
  logic [8*BB-1:0] wr_data;
  logic [BW-1:0] short_bytes;

  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  burst_read_master #(.BUS_BYTES(BB), .BUF_BYTES(BUFB)) dut (
    .clk(clk), .rst(rst), .buf_free(buf_free), .eod(eod), .rd_data(rd_data),
    .rd_strobe(rd_strobe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_full(commit_full), .short_commit(short_commit), .short_bytes(short_bytes));

  function automatic logic exp_write(int i, int k);
    return (i == WORDS - 1) || (i != k);
  endfunction

  function automatic int exp_bytes(int k);
    return k * BB;
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // k = data cycle carrying eod (k >= WORDS: never)
  task automatic burst(int k);
    logic [31:0] d;
    @(negedge clk); buf_free = 1; eod = 0; #1;
    chk("R2 strobe low before start", 32'(rd_strobe), 0);
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk); buf_free = 0; d = $urandom; rd_data = d; eod = (i == k); #1;
      chk("R3 strobe in data phase", 32'(rd_strobe), 1);
      chk("R5/R6 write enable", 32'(wr_en), 32'(exp_write(i, k)));
      if (exp_write(i, k)) begin
        chk("R3 word address", 32'(wr_addr), 32'(i));
        chk("R3 data passthrough", 32'(wr_data), d);
      end
      if (i == k && i != WORDS - 1) begin
        @(negedge clk); eod = 0; #1;
        chk("R5 short commit", 32'(short_commit), 1);
        chk("R5 short bytes", 32'(short_bytes), 32'(exp_bytes(k)));
        chk("R5 no full commit", 32'(commit_full), 0);
        chk("R5 strobe low", 32'(rd_strobe), 0);
        @(negedge clk); #1;
        chk("R8 short one cycle", 32'(short_commit), 0);
        chk("R8 idle after short", 32'(rd_strobe), 0);
        return;
      end
    end
    @(negedge clk); eod = 0; #1;
    chk("R4/R6 full commit", 32'(commit_full), 1);
    chk("R4/R6 no short commit", 32'(short_commit), 0);
    chk("R4 strobe low after last", 32'(rd_strobe), 0);
    @(negedge clk); #1;
    chk("R4 commit one cycle", 32'(commit_full), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset strobe", 32'(rd_strobe), 0);
    chk("R1 reset wr_en", 32'(wr_en), 0);
    chk("R1 reset commit", 32'(commit_full), 0);
    chk("R1 reset short", 32'(short_commit), 0);
    chk("R1 reset bytes", 32'(short_bytes), 0);
    @(negedge clk); rst = 0;
    // R2/R7: no buf_free, eod toggling in idle: stays idle
    for (int c = 0; c < 6; c++) begin
      @(negedge clk); eod = c[0]; #1;
      chk("R2/R7 idle holds", 32'(rd_strobe), 0);
      chk("R7 no short in idle", 32'(short_commit), 0);
    end
    eod = 0;
    burst(WORDS + 1);       // full, R4
    burst(0);               // short with zero words, R5
    burst(WORDS - 2);       // short just before last, R5
    burst(WORDS - 1);       // tie: eod with last word, R6
    burst(3);               // R8 back-to-back after short
    for (int b = 0; b < 40; b++) burst(int'($urandom % (WORDS + 4)));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule